// File: doc/BRIEF.md
# Receive Ring Buffer Pointer Controller

This block keeps the page pointers of a packet receive ring that lives in local SRAM. The ring is a run of 256-byte pages starting at a start page and ending just below a stop page. Incoming packet bytes go into the ring starting at the current page. When a packet ends, the current page moves to the first page after the packet's last byte. A packet is never allowed to write into the boundary page. The host owns that page as its read marker, and the block keeps it one page behind the host's next read page.

A separate remote DMA read channel loads a byte address. On every 16-bit read strobe it presents that address to the SRAM and then steps it by two. A read that passes the stop address of the ring folds back to the start of the ring. The block also reports when the ring is empty, and it raises an overflow flag when a packet is discarded for lack of room.

Top module: `rxring_ptr_ctl`

## Requirements
- R1: After reset the current page is 0x46, the boundary page is 0x5F, overflow is 0, empty is 1, and both SRAM enables are 0.
- R2: The bytes of a packet are written at consecutive byte addresses starting at current page × 256. The address after 0x5FFF is 0x4600.
- R3: When a packet ends without being dropped, the current page becomes the page that follows the last written byte. This wraps from 0x5F to 0x46. Overflow clears at the same time.
- R4: The write enable is never asserted for an address inside the boundary page. A packet that reaches the boundary page is dropped: the current page is unchanged and overflow is set.
- R5: A packet whose end would move the current page onto the boundary page is dropped in the same way.
- R6: A host read-page write stores boundary = read page − 1. Read page 0x46 gives boundary 0x5F.
- R7: A host read-page write with a page outside 0x46..0x5F has no effect on the boundary page.
- R8: Empty is 1 exactly when the page after the boundary page (with wrap) equals the current page.
- R9: Each DMA read strobe presents the current DMA address with the read enable high, and the address then advances by 2. A result at or above 0x6000 is reduced by 0x1A00, so 0x5FFE goes to 0x4600 and 0x5FFF goes to 0x4601.
- R10: A byte strobe outside a packet (no packet start seen) writes nothing and leaves the current page unchanged.
- R11: Once set, overflow stays set through host writes and further dropped packets, until a packet is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_begin | input | 1 | Start of an incoming packet |
| rx_byte | input | 1 | One packet byte is to be written this cycle |
| rx_end | input | 1 | End of the incoming packet |
| host_rd_wr | input | 1 | Host writes its next read page |
| host_rd_page | input | 8 | Host's next read page |
| dma_load | input | 1 | Load the DMA byte address |
| dma_load_addr | input | 16 | DMA start byte address |
| dma_rd | input | 1 | One 16-bit DMA read this cycle |
| sram_wr_en | output | 1 | SRAM byte write enable |
| sram_wr_addr | output | 16 | SRAM write byte address |
| sram_rd_en | output | 1 | SRAM read enable |
| sram_rd_addr | output | 16 | SRAM read byte address |
| curr_page | output | 8 | Current page for the next packet |
| bnry_page | output | 8 | Boundary page |
| overflow | output | 1 | A packet was dropped since the last accepted one |
| buf_empty | output | 1 | The ring holds no unread packet |

## Verification
A wrong write pointer shows up as a wrong SRAM write address on the very next byte strobe. A wrong end-of-packet page calculation shows up on curr_page and buf_empty one cycle after rx_end. If the boundary check is broken, an enable appears inside the host's page, or the current page moves onto the boundary. Either one is visible one cycle after the faulty event. Wrap faults stay hidden until a sequence crosses the top of the ring, so the stimulus deliberately places packets and DMA reads across the 0x5FFF/0x4600 seam.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  parameter int PG_W   = 8;
  parameter int OFS_W  = 8;
  localparam int ADDR_W = PG_W + OFS_W;

  typedef logic [PG_W-1:0]   page_t;
  typedef logic [ADDR_W-1:0] baddr_t;

  typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_DROP} rx_state_e;

  // page after p, wrapping from the last ring page to the first
  function automatic page_t pg_next(page_t p, page_t lo, page_t hi);
    page_t n;
    n = p + page_t'(1);
    return (n == hi) ? lo : n;
  endfunction

  // page before p, wrapping from the first ring page to the last
  function automatic page_t pg_prev(page_t p, page_t lo, page_t hi);
    return (p == lo) ? (hi - page_t'(1)) : (p - page_t'(1));
  endfunction

  function automatic logic pg_in_ring(page_t p, page_t lo, page_t hi);
    return (p >= lo) && (p < hi);
  endfunction

  // byte address plus step, folded back by the ring size past the stop
  function automatic baddr_t addr_adv(baddr_t a, logic [2:0] step,
                                      page_t lo, page_t hi);
    logic [ADDR_W:0] s;
    logic [ADDR_W:0] top;
    logic [ADDR_W:0] span;
    s    = {1'b0, a} + {{(ADDR_W-2){1'b0}}, step};
    top  = {1'b0, hi, {OFS_W{1'b0}}};
    span = top - {1'b0, lo, {OFS_W{1'b0}}};
    if (s >= top) s = s - span;
    return s[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/rxring_wr_ctl.sv
module rxring_wr_ctl
  import rxring_pkg::*;
#(
  parameter page_t START_PG = 8'h46,
  parameter page_t STOP_PG  = 8'h60
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rx_begin,
  input  logic   rx_byte,
  input  logic   rx_end,
  input  page_t  bnry,
  output logic   wr_en,
  output baddr_t wr_addr,
  output page_t  curr,
  output logic   ovf,
  output logic   commit,
  output logic   drop
);
  rx_state_e st;
  baddr_t    wr_ptr;
  page_t     wr_pg;
  page_t     end_pg;
  logic      hit_bnry;

  assign wr_pg    = wr_ptr[ADDR_W-1:OFS_W];
  assign hit_bnry = (wr_pg == bnry);
  assign end_pg   = (wr_ptr[OFS_W-1:0] == '0) ? wr_pg
                                              : pg_next(wr_pg, START_PG, STOP_PG);

  assign wr_en   = rx_byte && !rx_begin && (st == RX_FILL) && !hit_bnry;
  assign wr_addr = wr_ptr;
  assign commit  = rx_end && !rx_begin && (st == RX_FILL) && (end_pg != bnry);
  assign drop    = rx_end && !rx_begin &&
                   ((st == RX_DROP) || ((st == RX_FILL) && (end_pg == bnry)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      wr_ptr <= {START_PG, {OFS_W{1'b0}}};
      curr   <= START_PG;
      ovf    <= 1'b0;
    end else if (rx_begin) begin
      st     <= RX_FILL;
      wr_ptr <= {curr, {OFS_W{1'b0}}};
    end else if (rx_end) begin
      st <= RX_IDLE;
      if (commit) begin
        curr <= end_pg;
        ovf  <= 1'b0;
      end else if (drop) begin
        ovf  <= 1'b1;
      end
    end else if (rx_byte && st == RX_FILL) begin
      if (hit_bnry) st <= RX_DROP;
      else          wr_ptr <= addr_adv(wr_ptr, 3'd1, START_PG, STOP_PG);
    end
  end
endmodule

// File: rtl/rxring_bnry_reg.sv
module rxring_bnry_reg
  import rxring_pkg::*;
#(
  parameter page_t START_PG = 8'h46,
  parameter page_t STOP_PG  = 8'h60
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  host_wr,
  input  page_t host_page,
  output page_t bnry
);
  logic accept;
  assign accept = host_wr && pg_in_ring(host_page, START_PG, STOP_PG);

  always_ff @(posedge clk) begin
    if (!rst_n)      bnry <= STOP_PG - page_t'(1);
    else if (accept) bnry <= pg_prev(host_page, START_PG, STOP_PG);
  end
endmodule

// File: rtl/rxring_dma_rd.sv
module rxring_dma_rd
  import rxring_pkg::*;
#(
  parameter page_t START_PG = 8'h46,
  parameter page_t STOP_PG  = 8'h60
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  baddr_t load_addr,
  input  logic   rd,
  output logic   rd_en,
  output baddr_t rd_addr
);
  baddr_t ptr;

  assign rd_en   = rd && !load;
  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= {START_PG, {OFS_W{1'b0}}};
    else if (load)  ptr <= load_addr;
    else if (rd)    ptr <= addr_adv(ptr, 3'd2, START_PG, STOP_PG);
  end
endmodule

// File: rtl/rxring_ptr_ctl.sv
module rxring_ptr_ctl
  import rxring_pkg::*;
#(
  parameter page_t START_PG = 8'h46,
  parameter page_t STOP_PG  = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_begin,
  input  logic              rx_byte,
  input  logic              rx_end,
  input  logic              host_rd_wr,
  input  logic [PG_W-1:0]   host_rd_page,
  input  logic              dma_load,
  input  logic [ADDR_W-1:0] dma_load_addr,
  input  logic              dma_rd,
  output logic              sram_wr_en,
  output logic [ADDR_W-1:0] sram_wr_addr,
  output logic              sram_rd_en,
  output logic [ADDR_W-1:0] sram_rd_addr,
  output logic [PG_W-1:0]   curr_page,
  output logic [PG_W-1:0]   bnry_page,
  output logic              overflow,
  output logic              buf_empty
);
  page_t bnry;
  page_t curr;
  logic  pkt_commit;
  logic  pkt_drop;

  rxring_bnry_reg #(.START_PG(START_PG), .STOP_PG(STOP_PG)) u_bnry (
    .clk(clk), .rst_n(rst_n), .host_wr(host_rd_wr),
    .host_page(host_rd_page), .bnry(bnry)
  );

  rxring_wr_ctl #(.START_PG(START_PG), .STOP_PG(STOP_PG)) u_wr (
    .clk(clk), .rst_n(rst_n), .rx_begin(rx_begin), .rx_byte(rx_byte),
    .rx_end(rx_end), .bnry(bnry), .wr_en(sram_wr_en), .wr_addr(sram_wr_addr),
    .curr(curr), .ovf(overflow), .commit(pkt_commit), .drop(pkt_drop)
  );

  rxring_dma_rd #(.START_PG(START_PG), .STOP_PG(STOP_PG)) u_dma (
    .clk(clk), .rst_n(rst_n), .load(dma_load), .load_addr(dma_load_addr),
    .rd(dma_rd), .rd_en(sram_rd_en), .rd_addr(sram_rd_addr)
  );

  assign curr_page = curr;
  assign bnry_page = bnry;
  assign buf_empty = (pg_next(bnry, START_PG, STOP_PG) == curr);
endmodule

// File: rtl/rxring_ptr_chk.sv
module rxring_ptr_chk
  import rxring_pkg::*;
#(
  parameter page_t START_PG = 8'h46,
  parameter page_t STOP_PG  = 8'h60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rd_wr,
  input logic [PG_W-1:0]   host_rd_page,
  input logic              dma_load,
  input logic              dma_rd,
  input logic              sram_wr_en,
  input logic [ADDR_W-1:0] sram_wr_addr,
  input logic [ADDR_W-1:0] sram_rd_addr,
  input logic [PG_W-1:0]   curr_page,
  input logic [PG_W-1:0]   bnry_page,
  input logic              overflow,
  input logic              pkt_commit,
  input logic              pkt_drop
);
  localparam baddr_t RING_LO = {START_PG, {OFS_W{1'b0}}};
  localparam baddr_t RING_HI = {STOP_PG, {OFS_W{1'b0}}};

  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (curr_page == START_PG && bnry_page == STOP_PG - 8'd1 && !overflow));

  a_r4_no_wr_into_bnry: assert property (@(posedge clk) disable iff (!rst_n)
    sram_wr_en |-> (sram_wr_addr[ADDR_W-1:OFS_W] != bnry_page));

  a_r3_curr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (curr_page >= START_PG) && (curr_page < STOP_PG));

  a_r3_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_commit |=> !overflow);

  a_r11_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_drop |=> (overflow && $stable(curr_page)));

  a_r7_bad_page_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_wr && (host_rd_page < START_PG || host_rd_page >= STOP_PG)) |=> $stable(bnry_page));

  a_r9_dma_stays_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rd && !dma_load && sram_rd_addr >= RING_LO && sram_rd_addr < RING_HI)
      |=> (sram_rd_addr >= RING_LO && sram_rd_addr < RING_HI));
endmodule

bind rxring_ptr_ctl rxring_ptr_chk #(.START_PG(START_PG), .STOP_PG(STOP_PG)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd_wr(host_rd_wr), .host_rd_page(host_rd_page),
  .dma_load(dma_load), .dma_rd(dma_rd), .sram_wr_en(sram_wr_en),
  .sram_wr_addr(sram_wr_addr), .sram_rd_addr(sram_rd_addr), .curr_page(curr_page),
  .bnry_page(bnry_page), .overflow(overflow), .pkt_commit(pkt_commit),
  .pkt_drop(pkt_drop)
);

// File: tb/rxring_ptr_ctl_tb.sv
module rxring_ptr_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_begin = 1'b0, rx_byte = 1'b0, rx_end = 1'b0;
  logic        host_rd_wr = 1'b0;
  logic [7:0]  host_rd_page = 8'h00;
  logic        dma_load = 1'b0, dma_rd = 1'b0;
  logic [15:0] dma_load_addr = 16'h0;
  logic        sram_wr_en, sram_rd_en, overflow, buf_empty;
  logic [15:0] sram_wr_addr, sram_rd_addr;
  logic [7:0]  curr_page, bnry_page;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rxring_ptr_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .rx_begin(rx_begin), .rx_byte(rx_byte), .rx_end(rx_end),
    .host_rd_wr(host_rd_wr), .host_rd_page(host_rd_page), .dma_load(dma_load),
    .dma_load_addr(dma_load_addr), .dma_rd(dma_rd), .sram_wr_en(sram_wr_en),
    .sram_wr_addr(sram_wr_addr), .sram_rd_en(sram_rd_en), .sram_rd_addr(sram_rd_addr),
    .curr_page(curr_page), .bnry_page(bnry_page), .overflow(overflow), .buf_empty(buf_empty)
  );

  // host table: {read page written, expected boundary, expected empty}
  localparam logic [23:0] HOST_VEC [8] = '{
    {8'h46, 8'h5F, 8'h01}, {8'h48, 8'h47, 8'h00}, {8'h5F, 8'h5E, 8'h00},
    {8'h50, 8'h4F, 8'h00}, {8'h60, 8'h4F, 8'h00}, {8'h45, 8'h4F, 8'h00},
    {8'h00, 8'h4F, 8'h00}, {8'h46, 8'h5F, 8'h01}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic host_write(input logic [7:0] pg);
    host_rd_wr = 1'b1; host_rd_page = pg;
    cyc();
    host_rd_wr = 1'b0;
  endtask

  // packet of n bytes; byte 'probe' is checked for address and enable
  task automatic send_pkt(input int n, input int probe, input int exp_addr,
                          input bit exp_en, input string req);
    rx_begin = 1'b1;
    cyc();
    rx_begin = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_byte = 1'b1;
      #1;
      if (i == probe) begin
        chk(sram_wr_en == exp_en, req, "wr_en at probe", sram_wr_en, exp_en);
        if (exp_en)
          chk(sram_wr_addr == exp_addr[15:0], req, "wr_addr at probe", sram_wr_addr, exp_addr);
      end
      @(posedge clk); #1;
    end
    rx_byte = 1'b0;
    rx_end = 1'b1;
    cyc();
    rx_end = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(curr_page == 8'h46, "R1", "curr", curr_page, 8'h46);
    chk(bnry_page == 8'h5F, "R1", "bnry", bnry_page, 8'h5F);
    chk(!overflow, "R1", "overflow", overflow, 0);
    chk(buf_empty, "R1", "empty", buf_empty, 1);
    chk(!sram_wr_en && !sram_rd_en, "R1", "enables", {sram_wr_en, sram_rd_en}, 0);

    // table walk: R6, R7, R8
    for (int k = 0; k < 8; k++) begin
      host_write(HOST_VEC[k][23:16]);
      chk(bnry_page == HOST_VEC[k][15:8], (k >= 4 && k <= 6) ? "R7" : "R6",
          "bnry after host write", bnry_page, HOST_VEC[k][15:8]);
      chk(buf_empty == HOST_VEC[k][0], "R8", "empty after host write", buf_empty, HOST_VEC[k][0]);
    end

    // R2, R3: 300-byte packet from page 0x46 ends in page 0x47
    send_pkt(300, 0, 16'h4600, 1'b1, "R2");
    chk(curr_page == 8'h48, "R3", "curr after 300 bytes", curr_page, 8'h48);
    chk(!buf_empty, "R8", "not empty after packet", buf_empty, 0);
    chk(!overflow, "R3", "overflow after accept", overflow, 0);

    // R10 stray byte strobe
    rx_byte = 1'b1; #1;
    chk(!sram_wr_en, "R10", "stray wr_en", sram_wr_en, 0);
    cyc(); rx_byte = 1'b0; #1;
    chk(curr_page == 8'h48, "R10", "curr after stray byte", curr_page, 8'h48);

    // host reads up to page 0x48 -> boundary 0x47, empty
    host_write(8'h48);
    chk(bnry_page == 8'h47 && buf_empty, "R8", "empty after catch-up", {bnry_page, buf_empty}, 9'h08F);

    // fill pages 0x48..0x5E
    send_pkt(23 * 256, 23 * 256 - 1, 16'h5EFF, 1'b1, "R2");
    chk(curr_page == 8'h5F, "R3", "curr after long packet", curr_page, 8'h5F);

    // R5: wraps into page 0x46, end page 0x47 equals boundary -> dropped
    send_pkt(300, 256, 16'h4600, 1'b1, "R2");
    chk(curr_page == 8'h5F, "R5", "curr kept on drop", curr_page, 8'h5F);
    chk(overflow, "R5", "overflow on drop", overflow, 1);

    // R4: reaching the boundary page suppresses the write
    send_pkt(600, 512, 0, 1'b0, "R4");
    chk(curr_page == 8'h5F, "R4", "curr kept", curr_page, 8'h5F);
    chk(overflow, "R11", "overflow held over drop", overflow, 1);

    // R11: host write does not clear overflow
    host_write(8'h5F);
    chk(bnry_page == 8'h5E, "R6", "bnry 0x5E", bnry_page, 8'h5E);
    chk(overflow, "R11", "overflow held over host write", overflow, 1);
    chk(buf_empty, "R8", "empty with read page = curr", buf_empty, 1);

    // accepted wrapping packet: R3 wrap and overflow clear
    send_pkt(300, 256, 16'h4600, 1'b1, "R2");
    chk(curr_page == 8'h47, "R3", "curr after wrap", curr_page, 8'h47);
    chk(!overflow, "R11", "overflow cleared by accept", overflow, 0);

    // R9 DMA reads across the ring end
    chk(!sram_rd_en, "R9", "rd_en idle", sram_rd_en, 0);
    dma_load = 1'b1; dma_load_addr = 16'h5FFC;
    cyc();
    dma_load = 1'b0;
    begin
      logic [15:0] exp_seq [4];
      exp_seq = '{16'h5FFC, 16'h5FFE, 16'h4600, 16'h4602};
      for (int j = 0; j < 4; j++) begin
        dma_rd = 1'b1; #1;
        chk(sram_rd_en && sram_rd_addr == exp_seq[j], "R9", "dma addr",
            sram_rd_addr, exp_seq[j]);
        @(posedge clk); #1;
      end
    end
    dma_rd = 1'b0;
    dma_load = 1'b1; dma_load_addr = 16'h5FFF;
    cyc();
    dma_load = 1'b0; dma_rd = 1'b1;
    cyc();
    dma_rd = 1'b0; #1;
    chk(sram_rd_addr == 16'h4601, "R9", "odd wrap", sram_rd_addr, 16'h4601);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule